// File: doc/BRIEF.md
# Asynchronous Sample Rate Converter Core

This core re-times a stream of signed audio samples. Samples arrive on an input-rate strobe, and results leave on an unrelated, faster output-rate strobe. Both strobes are single-cycle enables in the same system clock domain.

Between input strobes, a fraction counter measures elapsed time in units of 1/2^20 of an input period. On each output tick the core freezes that fraction together with the current eight-sample history. It then evaluates the one polyphase branch of a virtual 2^20-times upsampling filter that lies at that instant. Taking the newest point of that fine grid behaves as a zero-order hold followed by resampling at the output rate. No integer L/M relation between the rates is needed.

The host programs the fraction increment per system clock to match the measured input period. A hold mode bypasses the filter and returns the newest input sample on every tick. This is plain re-clocking, kept for comparison. The output rate must be strictly above the input rate, and output ticks must be at least ten system clocks apart.

Top module: `asrc_core`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` and `overrun` are 0 and `res_data` is 0. All eight history entries are zero, so a tick issued straight after reset yields 0.
- R2: On each `smp_stb`, the history shifts. `smp_data` becomes entry 0 (newest), and entry k takes the old entry k-1. Tap k of the filter multiplies entry k.
- R3: The 20-bit fraction counter is cleared by `smp_stb`. Otherwise it adds `frac_step` every clock and saturates at 2^20-1. The fraction captured by a tick is the counter value before that clock's update.
- R4: Kernel value h(x) = floor(3·x·(512−x)/8) for x in 0..512. For a fraction f, let i = f[19:14] and m = f[13:6], and let j = 64·k + i. The coefficient of tap k is h(j) + floor((h(j+1)−h(j))·m/256), and it never leaves 0..24576.
- R5: The result is S = Σ entry_k·coef_k. It is rounded as floor((S + 2^16)/2^17).
- R6: `res_valid` is a one-cycle pulse on the 9th rising edge after the edge that accepted a tick. `res_data` changes only on that edge and holds otherwise.
- R7: A tick arriving while a computation is in progress (on any of the 9 following edges) is dropped. It sets `overrun`, which stays 1 until reset.
- R8: With `hold_mode` high at the accepting edge, the result is history entry 0 (the newest sample), with the same latency as R6.
- R9: A `smp_stb` coinciding with an accepted tick is applied first. The new sample is entry 0, and the captured fraction is 0.
- R10: The rounded result is saturated to the 24-bit signed range −2^23..2^23−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Input-rate strobe: a new sample is present |
| smp_data | input | 24 | Signed input sample |
| tick | input | 1 | Output-rate strobe requesting one result |
| frac_step | input | 20 | Fraction increment per system clock |
| hold_mode | input | 1 | 1 = re-clock the newest sample, 0 = interpolate |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Signed result, held between strobes |
| overrun | output | 1 | Sticky flag: a tick was dropped while busy |

## Verification
The interpolation path is driven with four input patterns:
- A single impulse sweeps every tap and phase in turn, so it exposes a wrong tap order, phase index or mix field.
- A constant level checks gain and rounding.
- A ramp separates neighbouring history entries, so a misaligned shift shows up.
- Full-scale constants and an alternating full-scale pattern drive both saturation limits.

Further runs force the fraction counter into saturation, place every tick on an input strobe, switch to hold mode, and space ticks closer than the computation length. Each of these isolates R3, R9, R8 and R7 in turn.

// File: rtl/asrc_pkg.sv
// Shared widths, types and the interpolation kernel for the rate converter.
// Assumes the defaults below; the kernel scale is chosen for a 512-point span.
package asrc_pkg;
    localparam int DATA_W     = 24;
    localparam int COEF_W     = 18;
    localparam int TAPS       = 8;
    localparam int PHASE_BITS = 6;
    localparam int MIX_BITS   = 8;
    localparam int FRAC_BITS  = 20;
    localparam int COEF_FRAC  = 17;
    localparam int KERN_SHIFT = 3;

    localparam int TAP_BITS = $clog2(TAPS);
    localparam int STEP_W   = $clog2(TAPS + 1);
    localparam int KSPAN    = TAPS << PHASE_BITS;
    localparam int KIDX_W   = $clog2(KSPAN + 1);
    localparam int KERN_W   = COEF_W - 1;
    localparam int ACC_W    = DATA_W + COEF_W + TAP_BITS;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [FRAC_BITS-1:0]     frac_t;
    typedef logic [KERN_W-1:0]        kern_t;

    // Parabolic window value at position x of the kernel span.
    function automatic kern_t kern_value(input int x);
        longint p;
        p = 3 * longint'(x) * longint'(KSPAN - x);
        return kern_t'(p >>> KERN_SHIFT);
    endfunction

    localparam int KMAX = (3 * (KSPAN / 2) * (KSPAN / 2)) >>> KERN_SHIFT;
endpackage

// File: rtl/asrc_history.sv
// Sample history: TAPS-deep shift register, entry 0 newest.
// Exposes next-state so a coincident strobe can be seen in the same cycle.
module asrc_history
    import asrc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [DATA_W-1:0]             din,
    output logic [TAPS-1:0][DATA_W-1:0]   hist_q,
    output logic [TAPS-1:0][DATA_W-1:0]   hist_d
);
    // Next state: shift in the new sample at entry 0 on a strobe.
    always_comb begin
        if (shift_en) hist_d = {hist_q[TAPS-2:0], din};
        else          hist_d = hist_q;
    end

    // History register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(din)) && (hist_q[1] == $past(hist_q[0]))); // R2
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q)); // R2
endmodule

// File: rtl/asrc_phase_meter.sv
// Fraction counter: measures time since the last input strobe in 1/2^FRAC_BITS
// units of an input period. Clears on a strobe, saturates at full scale.
module asrc_phase_meter
    import asrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  frac_t step,
    output frac_t phase_now
);
    frac_t                cnt_q;
    frac_t                cnt_d;
    logic [FRAC_BITS:0]   sum;

    // Saturating advance, or clear on a new input sample.
    always_comb begin
        sum = {1'b0, cnt_q} + {1'b0, step};
        if (restart)             cnt_d = '0;
        else if (sum[FRAC_BITS]) cnt_d = '1;
        else                     cnt_d = sum[FRAC_BITS-1:0];
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A coincident strobe is applied first, so its fraction reads zero.
    assign phase_now = restart ? '0 : cnt_q;

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R3
    AST_PHASE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (cnt_q >= $past(cnt_q))); // R3
endmodule

// File: rtl/asrc_coef_gen.sv
// Polyphase coefficient source: constant kernel table of KSPAN+1 points,
// linearly blended between neighbouring phases by the mix fraction.
module asrc_coef_gen
    import asrc_pkg::*;
(
    input  logic [TAP_BITS-1:0]   tap,
    input  logic [PHASE_BITS-1:0] idx,
    input  logic [MIX_BITS-1:0]   mix,
    output coef_t                 coef
);
    localparam int PW = KERN_W + MIX_BITS + 2;

    kern_t                     tab [0:KSPAN];
    logic [KIDX_W-1:0]         j0;
    logic [KIDX_W-1:0]         j1;
    logic signed [KERN_W:0]    diff;
    logic signed [PW-1:0]      prod;

    // Constant kernel table built from the package window function.
    for (genvar g = 0; g <= KSPAN; g++) begin : g_kern
        assign tab[g] = kern_value(g);
    end

    // Blend of the stored phase and its successor.
    always_comb begin
        j0   = KIDX_W'({tap, idx});
        j1   = j0 + KIDX_W'(1);
        diff = $signed({1'b0, tab[j1]}) - $signed({1'b0, tab[j0]});
        prod = PW'(diff) * PW'($signed({1'b0, mix}));
        coef = coef_t'(PW'($signed({1'b0, tab[j0]})) + (prod >>> MIX_BITS));
    end
endmodule

// File: rtl/asrc_mac.sv
// Multiply-accumulate sequencer: on an accepted tick it snapshots history and
// phase, runs one product per clock over all taps, then rounds, saturates and
// pulses the result. Ticks arriving while busy are dropped and flagged.
module asrc_mac
    import asrc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [TAPS-1:0][DATA_W-1:0] hist_in,
    input  frac_t                       phase_in,
    input  logic                        hold_in,
    output logic                        out_valid,
    output sample_t                     out_data,
    output logic                        overrun
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] SMAX = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SMIN = ~SMAX;

    logic                         busy_q;
    logic [STEP_W-1:0]            step_q;
    logic signed [ACC_W-1:0]      acc_q;
    logic [TAPS-1:0][DATA_W-1:0]  snap_q;
    logic [PHASE_BITS-1:0]        idx_q;
    logic [MIX_BITS-1:0]          mix_q;
    logic                         hold_q;
    coef_t                        coef;
    sample_t                      cur_smp;
    logic signed [ACC_W-1:0]      prod;
    logic signed [ACC_W-1:0]      scaled;
    sample_t                      sat;
    logic                         tap_run;

    asrc_coef_gen u_coef (
        .tap  (step_q[TAP_BITS-1:0]),
        .idx  (idx_q),
        .mix  (mix_q),
        .coef (coef)
    );

    // Current product and the rounded, clamped result of the accumulator.
    always_comb begin
        tap_run = busy_q && (step_q < STEP_W'(TAPS));
        cur_smp = sample_t'(snap_q[step_q[TAP_BITS-1:0]]);
        prod    = ACC_W'(cur_smp) * ACC_W'(coef);
        scaled  = (acc_q + HALF) >>> COEF_FRAC;
        if (scaled > SMAX)      sat = sample_t'(SMAX);
        else if (scaled < SMIN) sat = sample_t'(SMIN);
        else                    sat = sample_t'(scaled);
    end

    // Sequencer: accept, accumulate TAPS products, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            step_q    <= '0;
            acc_q     <= '0;
            snap_q    <= '0;
            idx_q     <= '0;
            mix_q     <= '0;
            hold_q    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (start && busy_q) overrun <= 1'b1;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                    acc_q  <= '0;
                    snap_q <= hist_in;
                    idx_q  <= phase_in[FRAC_BITS-1 -: PHASE_BITS];
                    mix_q  <= phase_in[FRAC_BITS-PHASE_BITS-1 -: MIX_BITS];
                    hold_q <= hold_in;
                end
            end else if (tap_run) begin
                acc_q  <= acc_q + prod;
                step_q <= step_q + STEP_W'(1);
            end else begin
                busy_q    <= 1'b0;
                out_valid <= 1'b1;
                out_data  <= hold_q ? sample_t'(snap_q[0]) : sat;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!busy_q && $past(busy_q))); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy_q) |=> overrun); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7
    AST_COEF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tap_run |-> ((coef >= 0) && (coef <= coef_t'(KMAX)))); // R4
endmodule

// File: rtl/asrc_core.sv
// Asynchronous sample rate converter core. Assumes both strobes are enables
// in the clk domain, the output rate exceeds the input rate, and ticks are at
// least TAPS+2 clocks apart.
module asrc_core
    import asrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [23:0]       smp_data,
    input  logic              tick,
    input  logic [19:0]       frac_step,
    input  logic              hold_mode,
    output logic              res_valid,
    output logic [23:0]       res_data,
    output logic              overrun
);
    logic [TAPS-1:0][DATA_W-1:0] hist_q;
    logic [TAPS-1:0][DATA_W-1:0] hist_d;
    frac_t                       phase_now;
    sample_t                     data_s;

    asrc_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (smp_stb),
        .din      (smp_data),
        .hist_q   (hist_q),
        .hist_d   (hist_d)
    );

    asrc_phase_meter u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (smp_stb),
        .step      (frac_step),
        .phase_now (phase_now)
    );

    asrc_mac u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tick),
        .hist_in   (hist_d),
        .phase_in  (phase_now),
        .hold_in   (hold_mode),
        .out_valid (res_valid),
        .out_data  (data_s),
        .overrun   (overrun)
    );

    assign res_data = data_s;
endmodule

// File: tb/asrc_core_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated each edge, compared each cycle.
module asrc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [23:0] smp_data = '0;
    logic        tick = 1'b0;
    logic [19:0] frac_step = '0;
    logic        hold_mode = 1'b0;
    logic        res_valid;
    logic [23:0] res_data;
    logic        overrun;

    always #2 clk = ~clk;

    asrc_core uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .tick(tick), .frac_step(frac_step), .hold_mode(hold_mode),
        .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
    );

    int     compared = 0;
    int     mismatched = 0;
    string  cur_req = "R1";
    int     hq[8];
    int     mcnt = 0;
    longint edge_n = 0;
    longint due = -100;
    int     pend_data = 0;
    bit     exp_valid = 0;
    int     exp_data = 0;
    bit     exp_ovr = 0;

    function automatic int kern(input int x);
        return (3 * x * (512 - x)) / 8;
    endfunction

    function automatic int expect_result(input int ph, input bit hold);
        longint acc = 0;
        longint r;
        int i = (ph >> 14) & 63;
        int m = (ph >> 6) & 255;
        if (hold) return hq[0];
        for (int k = 0; k < 8; k++) begin
            int j = 64 * k + i;
            int c = kern(j) + (((kern(j + 1) - kern(j)) * m) >>> 8);
            acc += longint'(hq[k]) * longint'(c);
        end
        r = (acc + 65536) >>> 17;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return int'(r);
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) hq[k] = 0;
            mcnt = 0; due = -100; exp_valid = 0; exp_data = 0; exp_ovr = 0;
        end else begin
            int old_cnt = mcnt;
            if (smp_stb) begin
                for (int k = 7; k > 0; k--) hq[k] = hq[k-1];
                hq[0] = int'($signed(smp_data));
                mcnt = 0;
            end else begin
                mcnt = old_cnt + int'(frac_step);
                if (mcnt > 20'hFFFFF) mcnt = 20'hFFFFF;
            end
            exp_valid = (edge_n == due);
            if (exp_valid) exp_data = pend_data;
            if (tick) begin
                if (edge_n <= due) exp_ovr = 1;
                else begin
                    pend_data = expect_result(smp_stb ? 0 : old_cnt, hold_mode);
                    due = edge_n + 9;
                end
            end
        end
        edge_n++;
    endtask

    task automatic compare();
        compared++;
        if (res_valid !== exp_valid) begin
            mismatched++;
            $display("FAIL %s res_valid actual %0b expected %0b", cur_req, res_valid, exp_valid);
        end
        if (res_data !== exp_data[23:0]) begin
            mismatched++;
            $display("FAIL %s res_data actual %0d expected %0d", cur_req,
                     $signed(res_data), exp_data);
        end
        if (overrun !== exp_ovr) begin
            mismatched++;
            $display("FAIL %s overrun actual %0b expected %0b", cur_req, overrun, exp_ovr);
        end
    endtask

    task automatic cyc(input bit s, input int d, input bit t);
        smp_stb = s; smp_data = d[23:0]; tick = t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    function automatic int pat_val(input int p, input int n);
        case (p)
            0: return (n == 0) ? 1000000 : 0;
            1: return 3000000;
            2: return n * 150000 - 2000000;
            3: return (n % 2) ? 8388607 : -8388608;
            4: return 8388607;
            default: return -8388608;
        endcase
    endfunction

    task automatic run(input int n, input int in_per, input int tick_per,
                       input int tick_off, input int pat);
        int sn = 0;
        for (int c = 0; c < n; c++) begin
            bit s;
            bit t;
            int d;
            s = (c % in_per == 0);
            t = (c % tick_per == tick_off);
            d = 0;
            if (s) begin d = pat_val(pat, sn); sn++; end
            cyc(s, d, t);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R6 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (3) cyc(0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 1);
        repeat (12) cyc(0, 0, 0);

        cur_req = "R2";  frac_step = 20'd28339; run(400, 37, 11, 3, 0);
        cur_req = "R4";  frac_step = 20'd36157; run(400, 29, 13, 5, 0);
        cur_req = "R5";  run(400, 29, 13, 5, 2);
        cur_req = "R6";  frac_step = 20'd25575; run(300, 41, 10, 7, 1);
        cur_req = "R10"; frac_step = 20'd28339; run(400, 37, 11, 2, 4);
        run(400, 37, 11, 6, 5);
        run(300, 33, 12, 4, 3);
        cur_req = "R3";  frac_step = 20'hFFFFF; run(200, 50, 17, 4, 2);
        cur_req = "R9";  frac_step = 20'd30000; run(300, 20, 20, 0, 2);
        cur_req = "R8";  hold_mode = 1'b1; run(300, 23, 12, 5, 2);
        hold_mode = 1'b0;
        cur_req = "R7";  run(60, 15, 4, 1, 2);
        run(100, 15, 12, 0, 1);
        finish_run();
    end
endmodule